// File: doc/BRIEF.md
# Special-Access Control Register Bank

This block is a small bank of four memory-mapped 32-bit control registers. Each register gives its accesses a different side effect. A plain synchronous bus reaches all four registers through a word address, a write enable with write data, and a read enable with registered read data. The logic that owns the bank has a second write port that reaches only the shared register. Two outputs pulse for one cycle each: one when the strobe register is written, and one when the trigger bit of the trigger register is written as 1.

The bus carries single-beat transfers. It has no valid/ready pair, because the bank accepts a read, a write, or both in every cycle and never applies back-pressure. Read data appears in the cycle after the read enable. A read and a write in the same cycle go to the same address. Everything runs on one clock with a synchronous, active-high reset.

Top module: `ctlreg_bank`

## Requirements
- R1: Reset sets the clear-on-read register (address 0), the shared register (address 1) and the trigger register (address 3) to zero. It loads the strobe register (address 2) with the parameter `STB_INIT`.
- R2: When `bus_re` is high in cycle N, `bus_rdata` in cycle N+1 holds the addressed register's value as it was before any update made in cycle N. In any cycle that follows no read, `bus_rdata` is zero.
- R3: A read of address 0 without a write clears that register at the next clock edge.
- R4: If address 0 is read and written in the same cycle, the written data is stored and the clear is dropped.
- R5: The shared register stores a bus write to address 1 and also stores an owner write (`own_we`). When both write in the same cycle, the owner's data is kept.
- R6: A bus write to address 2 never changes the value read back from that address. Every such write raises `evt_strobe` in the next cycle, even when the data matches the stored value.
- R7: Bit 31 of the trigger register (address 3) always reads as 0. Bits 30:0 store the written data.
- R8: A write to address 3 with bit 31 set raises `evt_trigger` in the next cycle. A write to address 3 with bit 31 clear raises no event.
- R9: Addresses 4 and above read as zero. Writes or reads to them change no register and raise no event.
- R10: Each event output is high for exactly one cycle per causing write. Both event outputs stay low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address for the bus access |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | DATA_W | Bus write data |
| bus_re | input | 1 | Bus read enable |
| bus_rdata | output | DATA_W | Registered read data, valid one cycle after `bus_re` |
| own_we | input | 1 | Owner write enable for the shared register |
| own_wdata | input | DATA_W | Owner write data |
| evt_strobe | output | 1 | One-cycle pulse after a write to the strobe register |
| evt_trigger | output | 1 | One-cycle pulse after a write of 1 to the trigger bit |

## Verification
The assertions check the following rules on every cycle:
- the clear after a lone read, and the write that wins when a read and a write meet on the clear-on-read register;
- owner priority on the shared register;
- that every event pulse traces back to a qualifying write;
- the zero trigger bit;
- zero read data for unmapped addresses.

Some behaviours show only in the bench's scenarios:
- the one-cycle read latency, with data taken from before the clear;
- that repeated writes of unchanged data still fire the strobe event;
- that the strobe register's value survives writes;
- that accesses to unmapped addresses leave the mapped registers as they were, and that a reset in mid-run restores the reset values.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int NREG = 4;
  localparam int IDX_RC  = 0;
  localparam int IDX_SHR = 1;
  localparam int IDX_STB = 2;
  localparam int IDX_TRG = 3;
endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode #(
  parameter int ADDR_W = 4,
  parameter int NREG   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              en,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/ctlreg_rc.sv
module ctlreg_rc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (wr_hit) q <= wdata;
    else if (rd_hit) q <= '0;
  end

  // R3
  rc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !wr_hit) |=> (q == '0));
  // R4
  rc_write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && wr_hit) |=> (q == $past(wdata)));
endmodule

// File: rtl/ctlreg_shared.sv
module ctlreg_shared #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_hit,
  input  logic [W-1:0] bus_wdata,
  input  logic         own_we,
  input  logic [W-1:0] own_wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (own_we)  q <= own_wdata;
    else if (bus_hit) q <= bus_wdata;
  end

  // R5
  shr_owner_wins_chk: assert property (@(posedge clk) disable iff (rst)
    own_we |=> (q == $past(own_wdata)));
  // R5
  shr_bus_store_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_hit && !own_we) |=> (q == $past(bus_wdata)));
endmodule

// File: rtl/ctlreg_evt.sv
module ctlreg_evt #(
  parameter int         W        = 32,
  parameter logic [W-1:0] STB_INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         stb_hit,
  input  logic         trg_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stb_q,
  output logic [W-1:0] trg_q,
  output logic         evt_stb,
  output logic         evt_trg
);
  localparam int TBIT = W - 1;

  logic [TBIT-1:0] trg_low;

  assign stb_q = STB_INIT;
  assign trg_q = {1'b0, trg_low};

  always_ff @(posedge clk) begin
    if (rst) begin
      trg_low <= '0;
      evt_stb <= 1'b0;
      evt_trg <= 1'b0;
    end else begin
      evt_stb <= stb_hit;
      evt_trg <= trg_hit && wdata[TBIT];
      if (trg_hit) trg_low <= wdata[TBIT-1:0];
    end
  end

  // R6
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    stb_hit |=> evt_stb);
  // R10
  stb_cause_chk: assert property (@(posedge clk) disable iff (rst)
    evt_stb |-> $past(stb_hit));
  // R8
  trg_cause_chk: assert property (@(posedge clk) disable iff (rst)
    evt_trg |-> ($past(trg_hit) && $past(wdata[TBIT])));
  // R8
  trg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (trg_hit && !wdata[TBIT]) |=> !evt_trg);
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank #(
  parameter int              ADDR_W   = 4,
  parameter int              DATA_W   = 32,
  parameter logic [DATA_W-1:0] STB_INIT = 32'hC0DE_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              own_we,
  input  logic [DATA_W-1:0] own_wdata,
  output logic              evt_strobe,
  output logic              evt_trigger
);
  import ctlreg_pkg::*;

  logic [NREG-1:0]   wr_hit;
  logic [NREG-1:0]   rd_hit;
  logic [DATA_W-1:0] val [NREG];
  logic [DATA_W-1:0] rd_mux;

  ctlreg_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_wdec (
    .addr(bus_addr), .en(bus_we), .hit(wr_hit));
  ctlreg_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_rdec (
    .addr(bus_addr), .en(bus_re), .hit(rd_hit));

  ctlreg_rc #(.W(DATA_W)) u_rc (
    .clk(clk), .rst(rst), .rd_hit(rd_hit[IDX_RC]), .wr_hit(wr_hit[IDX_RC]),
    .wdata(bus_wdata), .q(val[IDX_RC]));

  ctlreg_shared #(.W(DATA_W)) u_shr (
    .clk(clk), .rst(rst), .bus_hit(wr_hit[IDX_SHR]), .bus_wdata(bus_wdata),
    .own_we(own_we), .own_wdata(own_wdata), .q(val[IDX_SHR]));

  ctlreg_evt #(.W(DATA_W), .STB_INIT(STB_INIT)) u_evt (
    .clk(clk), .rst(rst), .stb_hit(wr_hit[IDX_STB]), .trg_hit(wr_hit[IDX_TRG]),
    .wdata(bus_wdata), .stb_q(val[IDX_STB]), .trg_q(val[IDX_TRG]),
    .evt_stb(evt_strobe), .evt_trg(evt_trigger));

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_hit[i]) rd_mux = rd_mux | val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(IDX_SHR)) |=> (bus_rdata == $past(val[IDX_SHR])));
  // R2
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> (bus_rdata == '0));
  // R7
  trg_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(IDX_TRG)) |=> !bus_rdata[DATA_W-1]);
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr >= ADDR_W'(NREG)) |=> (bus_rdata == '0));
endmodule

// File: tb/ctlreg_bank_bench.sv
module ctlreg_bank_bench;
  localparam logic [31:0] INIT = 32'hC0DE_0001;

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic        re;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic        own;
    logic [31:0] owndata;
    logic [31:0] exp_rd;
    logic        exp_s;
    logic        exp_t;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  1'b1, 1'b0, 4'd0, 32'h11,       1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R3 load
    '{4'd2,  1'b0, 1'b1, 4'd0, 32'h0,        1'b0, 32'h0,    32'h11,       1'b0, 1'b0}, // R2 read
    '{4'd3,  1'b0, 1'b1, 4'd0, 32'h0,        1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R3 cleared
    '{4'd4,  1'b1, 1'b0, 4'd0, 32'h22,       1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R4
    '{4'd4,  1'b1, 1'b1, 4'd0, 32'h33,       1'b0, 32'h0,    32'h22,       1'b0, 1'b0}, // R4 old value
    '{4'd4,  1'b0, 1'b1, 4'd0, 32'h0,        1'b0, 32'h0,    32'h33,       1'b0, 1'b0}, // R4 write kept
    '{4'd3,  1'b0, 1'b1, 4'd0, 32'h0,        1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R3
    '{4'd5,  1'b1, 1'b0, 4'd1, 32'hAAAA,     1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R5 bus
    '{4'd5,  1'b0, 1'b1, 4'd1, 32'h0,        1'b0, 32'h0,    32'hAAAA,     1'b0, 1'b0}, // R5
    '{4'd5,  1'b1, 1'b0, 4'd1, 32'h1234,     1'b1, 32'h5678, 32'h0,        1'b0, 1'b0}, // R5 both
    '{4'd5,  1'b0, 1'b1, 4'd1, 32'h0,        1'b0, 32'h0,    32'h5678,     1'b0, 1'b0}, // R5 owner wins
    '{4'd2,  1'b0, 1'b1, 4'd1, 32'h0,        1'b1, 32'h9,    32'h5678,     1'b0, 1'b0}, // R2 pre-update
    '{4'd5,  1'b0, 1'b1, 4'd1, 32'h0,        1'b0, 32'h0,    32'h9,        1'b0, 1'b0}, // R5 owner only
    '{4'd6,  1'b1, 1'b0, 4'd2, 32'hFFFF,     1'b0, 32'h0,    32'h0,        1'b1, 1'b0}, // R6
    '{4'd6,  1'b1, 1'b0, 4'd2, 32'hFFFF,     1'b0, 32'h0,    32'h0,        1'b1, 1'b0}, // R6 repeat
    '{4'd6,  1'b0, 1'b1, 4'd2, 32'h0,        1'b0, 32'h0,    INIT,         1'b0, 1'b0}, // R6 unchanged
    '{4'd6,  1'b1, 1'b0, 4'd2, INIT,         1'b0, 32'h0,    32'h0,        1'b1, 1'b0}, // R6 same data
    '{4'd8,  1'b1, 1'b0, 4'd3, 32'hFFFFFFFF, 1'b0, 32'h0,    32'h0,        1'b0, 1'b1}, // R8
    '{4'd7,  1'b0, 1'b1, 4'd3, 32'h0,        1'b0, 32'h0,    32'h7FFFFFFF, 1'b0, 1'b0}, // R7 R10
    '{4'd8,  1'b1, 1'b0, 4'd3, 32'h5,        1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R8 no event
    '{4'd7,  1'b0, 1'b1, 4'd3, 32'h0,        1'b0, 32'h0,    32'h5,        1'b0, 1'b0}, // R7
    '{4'd8,  1'b1, 1'b0, 4'd3, 32'h80000000, 1'b0, 32'h0,    32'h0,        1'b0, 1'b1}, // R8
    '{4'd7,  1'b0, 1'b1, 4'd3, 32'h0,        1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R7 bit 31 not kept
    '{4'd9,  1'b1, 1'b0, 4'd7, 32'hDEAD,     1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R9
    '{4'd9,  1'b0, 1'b1, 4'd7, 32'h0,        1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R9
    '{4'd9,  1'b1, 1'b1, 4'd5, 32'hFFFFFFFF, 1'b0, 32'h0,    32'h0,        1'b0, 1'b0}, // R9
    '{4'd9,  1'b0, 1'b1, 4'd1, 32'h0,        1'b0, 32'h0,    32'h9,        1'b0, 1'b0}  // R9 shared kept
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        own_we = 1'b0;
  logic [31:0] own_wdata = '0;
  logic        evt_strobe;
  logic        evt_trigger;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctlreg_bank #(.ADDR_W(4), .DATA_W(32), .STB_INIT(INIT)) u_ctlreg_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .own_we(own_we), .own_wdata(own_wdata),
    .evt_strobe(evt_strobe), .evt_trigger(evt_trigger));

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic re, input logic [3:0] a,
                       input logic [31:0] d, input logic ow, input logic [31:0] od);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    own_we = ow; own_wdata = od;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 4'd0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic read_chk(input int req, input logic [3:0] a, input logic [31:0] exp);
    drive(1'b0, 1'b1, a, 32'h0, 1'b0, 32'h0);
    @(posedge clk); @(negedge clk);
    check(req, "read", bus_rdata, exp);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(10, "evt_strobe in reset", {31'b0, evt_strobe}, 32'h0);
    check(10, "evt_trigger in reset", {31'b0, evt_trigger}, 32'h0);
    rst = 1'b0;
    // R1 reset values
    read_chk(1, 4'd0, 32'h0);
    read_chk(1, 4'd1, 32'h0);
    read_chk(1, 4'd2, INIT);
    read_chk(1, 4'd3, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].we, VEC[i].re, VEC[i].addr, VEC[i].wdata, VEC[i].own, VEC[i].owndata);
      @(posedge clk); @(negedge clk);
      check(int'(VEC[i].req), $sformatf("vec %0d rdata", i), bus_rdata, VEC[i].exp_rd);
      check(int'(VEC[i].req), $sformatf("vec %0d evt_strobe", i), {31'b0, evt_strobe}, {31'b0, VEC[i].exp_s});
      check(int'(VEC[i].req), $sformatf("vec %0d evt_trigger", i), {31'b0, evt_trigger}, {31'b0, VEC[i].exp_t});
    end
    idle();

    // R10: a strobe write just before reset; the pulse is dropped
    drive(1'b1, 1'b0, 4'd0, 32'h44, 1'b1, 32'h77);
    @(negedge clk);
    drive(1'b1, 1'b0, 4'd2, 32'h1, 1'b0, 32'h0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(10, "evt_strobe held low in reset", {31'b0, evt_strobe}, 32'h0);
    idle();
    @(negedge clk);
    rst = 1'b0;
    // R1 reset in mid-run
    read_chk(1, 4'd0, 32'h0);
    read_chk(1, 4'd1, 32'h0);
    read_chk(1, 4'd2, INIT);
    check(10, "evt_strobe after reset", {31'b0, evt_strobe}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule